// File: doc/BRIEF.md
# Receive Word Queue with First-Error Code Register

This block sits between a serial frame decoder and a processor-style read port. The decoder hands over each decoded word with a one-cycle push strobe and reports line faults as one-cycle pulses on a five-bit error input. Words are held in a three-entry queue. The processor side sees a combinational read port that shows either the oldest queued word or an error code byte. A select input picks between the two, and a read strobe acts on the current selection.

Only the first fault after the receiver was last made idle is recorded. While a fault is recorded, the receiver drops further decoder words and hides the data-available flag. Words that arrived before the fault stay in the queue. Reading the error code acknowledges the fault and brings data-available back. A transceiver reset input clears the queue, the flags and the code at any time.

Top module: `rcv_fifo_errreg`

## Requirements
- R1: Words leave the queue in arrival order. `rd_data` shows the oldest word combinationally, and a read with `sel_err`=0 pops it. A read of an empty queue leaves it empty, and `rd_data` keeps showing the last word popped.
- R2: `full` is 1 exactly when three words are held. `data_avail` is 1 when at least one word is held and no fault is recorded.
- R3: A push while the queue is full, with no pop in the same cycle, is an overrun. The incoming word replaces the newest (third) entry, the two oldest entries are kept, and code 5'b10000 is recorded.
- R4: Code bit meanings: bit 4 overrun, bit 3 parity fault, bit 2 bad end sequence, bit 1 lost mid-bit transition, bit 0 receiver disabled while active. With `sel_err`=1, `rd_data` = {oldest word bits 7:5, code bits 4:0}.
- R5: Only the first fault is kept. Later pulses leave the code unchanged. If several pulses arrive in one cycle, the highest-numbered bit alone is recorded.
- R6: A read with `sel_err`=1 clears the code and `rx_err` on the next edge and pops no word. Error pulses in that same cycle are dropped.
- R7: While `rx_err` is 1, `data_avail` is 0. After the code is read, `data_avail` returns and the words held before the fault can be read in order.
- R8: Decoder pushes while a fault is recorded are discarded.
- R9: `xcvr_rst` empties the queue and clears `full`, `data_avail`, `rx_err` and the code. `rd_data` then reads 0 under either select.
- R10: A push and a pop in the same cycle on a full queue is not an overrun. The oldest word leaves, the new word enters last, and `full` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xcvr_rst | input | 1 | Transceiver reset: clears queue, flags and code |
| dec_push | input | 1 | Decoder word strobe |
| dec_word | input | 8 | Decoded word |
| dec_err | input | 5 | Decoder fault pulses (bit meanings in R4) |
| cpu_rd | input | 1 | Read strobe, acting on the current selection |
| sel_err | input | 1 | 1 selects the error code byte, 0 selects the oldest word |
| rd_data | output | 8 | Read data |
| full | output | 1 | Three words held |
| data_avail | output | 1 | Word available and no fault recorded |
| rx_err | output | 1 | A fault is recorded |

## Verification
Every result here is due on the first clock edge after the stimulus. A push, pop, pulse, acknowledge or transceiver reset sampled at one rising edge changes the flags right after that edge. `rd_data` follows `sel_err` with no edge at all. The bench therefore drives inputs on the falling edge and checks `rd_data` before the strobe's rising edge. It checks the flags on the falling edge that follows, so each check falls exactly one register stage after its cause.

// File: rtl/rcv_fifo_pkg.sv
package rcv_fifo_pkg;

    localparam int ERR_W = 5;

    localparam int BIT_OVERRUN   = 4;
    localparam int BIT_PARITY    = 3;
    localparam int BIT_BAD_END   = 2;
    localparam int BIT_LOST_MID  = 1;
    localparam int BIT_TX_STEAL  = 0;

    typedef logic [ERR_W-1:0] err_code_t;

    typedef struct packed {
        logic push;
        logic pop;
        logic ack;
    } rq_op_t;

    function automatic err_code_t first_err(input err_code_t req);
        err_code_t pick;
        pick = '0;
        for (int b = ERR_W - 1; b >= 0; b--) begin
            if (req[b] && (pick == '0)) pick[b] = 1'b1;
        end
        return pick;
    endfunction

    function automatic err_code_t overrun_code(input logic hit);
        err_code_t c;
        c = '0;
        c[BIT_OVERRUN] = hit;
        return c;
    endfunction

endpackage

// File: rtl/rcv_word_store.sv
module rcv_word_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 3,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              push_en,
    input  logic              pop_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  fill,
    output logic              is_full,
    output logic              overrun
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] slot [DEPTH];
    logic [CNT_W-1:0]  fill_q;
    logic [IDX_W-1:0]  tail_idx;
    logic [IDX_W-1:0]  last_idx;
    logic              has_word;

    assign has_word = (fill_q != '0);
    assign is_full  = (fill_q == CNT_W'(DEPTH));
    assign overrun  = push_en && is_full && !pop_en;
    assign tail_idx = IDX_W'(fill_q);
    assign last_idx = IDX_W'(fill_q - CNT_W'(1));
    assign head     = slot[0];
    assign fill     = fill_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            fill_q <= '0;
            for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
        end else if (pop_en && has_word) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (CNT_W'(i + 1) < fill_q) slot[i] <= slot[i + 1];
            end
            if (push_en) slot[last_idx] <= wdata;
            else         fill_q <= fill_q - CNT_W'(1);
        end else if (push_en) begin
            if (is_full) begin
                slot[DEPTH - 1] <= wdata;
            end else begin
                slot[tail_idx] <= wdata;
                fill_q <= fill_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/rcv_err_latch.sv
module rcv_err_latch
    import rcv_fifo_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      ack,
    input  err_code_t src,
    output err_code_t code,
    output logic      active
);
    err_code_t code_q;

    assign code   = code_q;
    assign active = (code_q != '0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            code_q <= '0;
        end else if (ack) begin
            code_q <= '0;
        end else if ((code_q == '0) && (src != '0)) begin
            code_q <= first_err(src);
        end
    end

endmodule

// File: rtl/rcv_read_mux.sv
module rcv_read_mux
    import rcv_fifo_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              sel_code,
    input  logic [DATA_W-1:0] head,
    input  err_code_t         code,
    output logic [DATA_W-1:0] dout
);
    always_comb begin
        if (sel_code) dout = {head[DATA_W-1:ERR_W], code};
        else          dout = head;
    end

endmodule

// File: rtl/rcv_fifo_errreg.sv
module rcv_fifo_errreg
    import rcv_fifo_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xcvr_rst,
    input  logic              dec_push,
    input  logic [DATA_W-1:0] dec_word,
    input  logic [ERR_W-1:0]  dec_err,
    input  logic              cpu_rd,
    input  logic              sel_err,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              data_avail,
    output logic              rx_err
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    rq_op_t            op;
    logic [DATA_W-1:0] head_word;
    logic [CNT_W-1:0]  fill_cnt;
    logic              ovr_hit;
    err_code_t         err_code_q;
    err_code_t         err_src;

    assign op.push = dec_push && !rx_err;
    assign op.pop  = cpu_rd && !sel_err;
    assign op.ack  = cpu_rd && sel_err;

    assign err_src    = dec_err | overrun_code(ovr_hit);
    assign data_avail = (fill_cnt != '0) && !rx_err;

    rcv_word_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .CNT_W  (CNT_W)
    ) store_i (
        .clk     (clk),
        .rst     (rst),
        .clr     (xcvr_rst),
        .push_en (op.push),
        .pop_en  (op.pop),
        .wdata   (dec_word),
        .head    (head_word),
        .fill    (fill_cnt),
        .is_full (full),
        .overrun (ovr_hit)
    );

    rcv_err_latch err_i (
        .clk    (clk),
        .rst    (rst),
        .clr    (xcvr_rst),
        .ack    (op.ack),
        .src    (err_src),
        .code   (err_code_q),
        .active (rx_err)
    );

    rcv_read_mux #(
        .DATA_W (DATA_W)
    ) mux_i (
        .sel_code (sel_err),
        .head     (head_word),
        .code     (err_code_q),
        .dout     (rd_data)
    );

endmodule

// File: rtl/rcv_fifo_errreg_chk.sv
module rcv_fifo_errreg_chk
    import rcv_fifo_pkg::*;
#(
    parameter int DEPTH = 3,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             xcvr_rst,
    input logic             dec_push,
    input logic [ERR_W-1:0] dec_err,
    input logic             cpu_rd,
    input logic             sel_err,
    input logic             full,
    input logic             data_avail,
    input logic             rx_err,
    input err_code_t        err_code,
    input logic [CNT_W-1:0] fill
);
    // R3: overrun records the overrun code alone
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (full && dec_push && !cpu_rd && !rx_err && !xcvr_rst) |=> (err_code == 5'b10000));

    // R4/R5: at most one code bit ever set
    p_single_code_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(err_code));

    // R5: a recorded fault is held until acknowledged
    p_first_kept_r5: assert property (@(posedge clk) disable iff (rst)
        (rx_err && !(cpu_rd && sel_err) && !xcvr_rst) |=> $stable(err_code));

    // R6: acknowledge clears the fault and pops nothing
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && sel_err && !xcvr_rst) |=> (!rx_err && $stable(fill)));

    // R7: data-available returns after the acknowledge
    p_dav_back_r7: assert property (@(posedge clk) disable iff (rst)
        (rx_err && cpu_rd && sel_err && (fill != '0) && !xcvr_rst) |=> data_avail);

    // R8: pushes during a fault do not change the fill
    p_drop_push_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_err && dec_push && !cpu_rd && !xcvr_rst) |=> $stable(fill));

    // R9: transceiver reset clears everything
    p_xrst_clears_r9: assert property (@(posedge clk) disable iff (rst)
        xcvr_rst |=> (!full && !data_avail && !rx_err && (fill == '0)));

    // R10: push with pop on a full queue keeps it full without fault
    p_swap_full_r10: assert property (@(posedge clk) disable iff (rst)
        (full && dec_push && cpu_rd && !sel_err && !rx_err && !xcvr_rst && (dec_err == '0))
        |=> (full && !rx_err));

endmodule

bind rcv_fifo_errreg rcv_fifo_errreg_chk #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .xcvr_rst   (xcvr_rst),
    .dec_push   (dec_push),
    .dec_err    (dec_err),
    .cpu_rd     (cpu_rd),
    .sel_err    (sel_err),
    .full       (full),
    .data_avail (data_avail),
    .rx_err     (rx_err),
    .err_code   (err_code_q),
    .fill       (fill_cnt)
);

// File: tb/rcv_fifo_errreg_tb_top.sv
`timescale 1ns/1ps
module rcv_fifo_errreg_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       xcvr_rst = 1'b0;
    logic       dec_push = 1'b0;
    logic [7:0] dec_word = '0;
    logic [4:0] dec_err = '0;
    logic       cpu_rd = 1'b0;
    logic       sel_err = 1'b0;
    logic [7:0] rd_data;
    logic       full, data_avail, rx_err;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rcv_fifo_errreg dut_i (
        .clk(clk), .rst(rst), .xcvr_rst(xcvr_rst),
        .dec_push(dec_push), .dec_word(dec_word), .dec_err(dec_err),
        .cpu_rd(cpu_rd), .sel_err(sel_err), .rd_data(rd_data),
        .full(full), .data_avail(data_avail), .rx_err(rx_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push(input logic [7:0] w);
        dec_push = 1'b1; dec_word = w;
        tick();
        dec_push = 1'b0;
    endtask

    task automatic rd_word(input logic [7:0] exp, input string tag);
        sel_err = 1'b0;
        #1;
        check(rd_data == exp, tag, rd_data, exp);
        cpu_rd = 1'b1;
        tick();
        cpu_rd = 1'b0;
    endtask

    task automatic rd_code(input logic [7:0] exp, input string tag);
        sel_err = 1'b1;
        #1;
        check(rd_data == exp, tag, rd_data, exp);
        cpu_rd = 1'b1;
        tick();
        cpu_rd = 1'b0;
        sel_err = 1'b0;
    endtask

    task automatic pulse(input logic [4:0] e);
        dec_err = e;
        tick();
        dec_err = '0;
    endtask

    task automatic xreset();
        xcvr_rst = 1'b1;
        tick();
        xcvr_rst = 1'b0;
    endtask

    task automatic t_reset_state();
        check(!full && !data_avail && !rx_err, "R9 reset flags", {full, data_avail, rx_err}, 0);
        check(rd_data == 8'h00, "R9 reset data", rd_data, 0);
    endtask

    task automatic t_order();
        xreset();
        push(8'h5A);
        check(data_avail && !full, "R2 one word", {full, data_avail}, 1);
        push(8'h6B);
        push(8'h7C);
        check(full, "R2 full at three", full, 1);
        rd_word(8'h5A, "R1 first out");
        check(!full && data_avail, "R2 not full after pop", {full, data_avail}, 1);
        rd_word(8'h6B, "R1 second out");
        rd_word(8'h7C, "R1 third out");
        check(!data_avail, "R2 empty", data_avail, 0);
        rd_word(8'h7C, "R1 empty read keeps last");
        check(rd_data == 8'h7C && !data_avail && !full, "R1 empty read no change", rd_data, 8'h7C);
    endtask

    task automatic t_overrun();
        xreset();
        push(8'hA1); push(8'hB2); push(8'hC3);
        push(8'hD4);
        check(rx_err && full, "R3 overrun flagged", {rx_err, full}, 3);
        check(!data_avail, "R7 dav hidden", data_avail, 0);
        rd_code(8'hB0, "R4 code byte with head bits");
        check(!rx_err && data_avail, "R7 dav restored", {rx_err, data_avail}, 1);
        rd_word(8'hA1, "R3 oldest kept");
        rd_word(8'hB2, "R3 second kept");
        rd_word(8'hD4, "R3 newest replaced");
    endtask

    task automatic t_first_only();
        xreset();
        pulse(5'b00010);
        pulse(5'b01000);
        rd_code(8'h02, "R5 first kept");
        pulse(5'b00110);
        rd_code(8'h04, "R5 priority");
        pulse(5'b11111);
        rd_code(8'h10, "R5 top bit wins");
    endtask

    task automatic t_parity_with_data();
        xreset();
        push(8'hE0);
        pulse(5'b01000);
        check(rx_err && !data_avail, "R7 error hides dav", {rx_err, data_avail}, 2);
        rd_code(8'hE8, "R4 parity bit 3");
        check(data_avail, "R7 dav back", data_avail, 1);
        rd_word(8'hE0, "R7 word kept");
    endtask

    task automatic t_drop_push();
        xreset();
        pulse(5'b00001);
        push(8'h55);
        rd_code(8'h01, "R8 code and head");
        check(!data_avail && !full, "R8 push discarded", {full, data_avail}, 0);
    endtask

    task automatic t_ack_drop();
        xreset();
        pulse(5'b00001);
        sel_err = 1'b1; cpu_rd = 1'b1; dec_err = 5'b00100;
        tick();
        cpu_rd = 1'b0; dec_err = '0;
        #1;
        check(!rx_err, "R6 ack clears", rx_err, 0);
        check(rd_data[4:0] == 5'b00000, "R6 pulse dropped", rd_data[4:0], 0);
        sel_err = 1'b0;
    endtask

    task automatic t_swap_full();
        xreset();
        push(8'h11); push(8'h22); push(8'h33);
        #1;
        check(rd_data == 8'h11, "R10 head before swap", rd_data, 8'h11);
        dec_push = 1'b1; dec_word = 8'h44; cpu_rd = 1'b1;
        tick();
        dec_push = 1'b0; cpu_rd = 1'b0;
        check(full && !rx_err, "R10 no overrun", {full, rx_err}, 2);
        rd_word(8'h22, "R10 order a");
        rd_word(8'h33, "R10 order b");
        rd_word(8'h44, "R10 order c");
    endtask

    task automatic t_xrst();
        xreset();
        push(8'hF7); push(8'h9C);
        pulse(5'b00010);
        xreset();
        check(!full && !data_avail && !rx_err, "R9 flags cleared", {full, data_avail, rx_err}, 0);
        #1;
        check(rd_data == 8'h00, "R9 word cleared", rd_data, 0);
        sel_err = 1'b1;
        #1;
        check(rd_data == 8'h00, "R9 code cleared", rd_data, 0);
        sel_err = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_order();
        t_overrun();
        t_first_only();
        t_parity_with_data();
        t_drop_push();
        t_ack_drop();
        t_swap_full();
        t_xrst();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule